// File: doc/BRIEF.md
# Best-Fit Clock Divisor Search Engine

This block chooses the settings for a programmable clock divider so that the generated frequency lands as close as possible to a requested frequency. It is given the request and the rates of three candidate sources: a fixed reference, a first PLL and a second PLL. Each source can be followed by a fractional predivider (2, 2.5 or 3) and an integer divider from 2 to 127. The engine walks through every source and predivider pairing. For each pairing it computes the integer divider that best matches the request and the frequency that divider would produce. It keeps the pairing with the smallest error.

A search starts with a one-cycle `start` pulse while the engine is idle. All rate inputs are captured at that point. The engine then runs for several hundred cycles on a single shared multi-cycle restoring divider. It ends with a one-cycle `done` pulse. The chosen source selects, predivider code, divider and achieved frequency are held until the next accepted start. Each source rate is doubled before use, so the half-step predividers become the integer factors 4, 5 and 6. All arithmetic is therefore exact integer arithmetic on 40-bit intermediates.

Top module: `rate_fit_search`

## Requirements
- R1: A `start` pulse seen while `busy` is low captures `req_rate`, `ref_rate`, `pll_a_rate` and `pll_b_rate`, and `busy` is high on the next cycle. A `start` seen while `busy` is high is ignored: the running search is unaffected and no extra `done` occurs.
- R2: Before searching, the request is limited to the largest of `ref_rate/4`, `pll_a_rate/4` and `pll_b_rate/4`, each quotient truncated. This limited value is the target used in R4 and R5.
- R3: Candidates are visited with the source as the outer loop and the factor as the inner loop. Sources go in the order reference, first PLL, second PLL. Factors go 4, 5, 6, standing for predividers 2, 2.5 and 3.
- R4: A candidate's divider is floor(2*source / (target*factor)). A candidate whose divider is below 2 or above 127 is discarded. A target of 0 makes every candidate invalid.
- R5: A valid candidate's achieved rate is floor(2*source / (factor*divider)). Its error is the absolute difference between the achieved rate and the target.
- R6: A valid candidate becomes the best one only if no valid candidate has been seen yet, or if its error is strictly smaller than the best error so far. On equal error, the earlier candidate in R3 order is kept.
- R7: Result encoding. `sel_pll` is 1 when the winner uses either PLL. `sel_pll_b` is 1 only when the winner uses the second PLL. `pre_code` equals factor minus 3, so it is 1, 2 or 3. `div_val` is the divider. `achieved` is the winner's achieved rate. `found` is 1.
- R8: When no candidate is valid, `found`, `achieved`, `div_val`, `pre_code`, `sel_pll` and `sel_pll_b` are all 0 at `done`.
- R9: `done` is high for exactly one cycle, and `busy` is low on the cycle after it. The result outputs keep their values from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (honoured only when idle) |
| req_rate | input | 32 | Requested output frequency |
| ref_rate | input | 32 | Reference source frequency |
| pll_a_rate | input | 32 | First PLL frequency |
| pll_b_rate | input | 32 | Second PLL frequency (0 when off) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A valid candidate exists |
| sel_pll | output | 1 | Winner uses a PLL |
| sel_pll_b | output | 1 | Winner uses the second PLL |
| pre_code | output | 2 | Predivider code (factor minus 3) |
| div_val | output | 7 | Integer divider of the winner |
| achieved | output | 32 | Frequency the winner produces |

## Verification
The hardest situation to reach from the ports is an exact tie in error between candidates from different sources. In normal use the source rates differ, so the rule that keeps the earlier candidate is never put to the test. The stimulus sets all three sources to the same rate and picks a request that one factor divides exactly. Every source then offers the same zero-error candidate, and the winner must still be the reference. Further jobs zero out the reference and the first PLL to force the second PLL to win. Others push the request above the limit, to zero, or so low that every divider overflows. The remaining case pulses `start` in the middle of a search to show that it is ignored.

// File: rtl/rate_fit_pkg.sv
package rate_fit_pkg;
  localparam int NSRC     = 3;   // reference, first PLL, second PLL
  localparam int NPRE     = 3;   // factors 4, 5, 6
  localparam int PRE_BASE = 4;   // doubled predivider 2.0

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QGO,
    ST_QWAIT,
    ST_AGO,
    ST_AWAIT,
    ST_NEXT,
    ST_DONE
  } fit_state_e;
endpackage

// File: rtl/rate_fit_udiv.sv
module rate_fit_udiv #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  rem, acc, dvs_q, dvd_q;
  logic          run;

  // one restoring step: bring down the next dividend bit, try to subtract
  logic [W:0] shifted;
  logic       step_ge;
  logic [W:0] step_diff;
  assign shifted   = {rem, acc[W-1]};
  assign step_ge   = shifted >= {1'b0, dvs_q};
  assign step_diff = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      rem   <= '0;
      acc   <= '0;
      dvs_q <= '0;
      dvd_q <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !run) begin
        acc   <= dvd;
        dvd_q <= dvd;
        dvs_q <= dvs;
        rem   <= '0;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        rem <= step_ge ? step_diff[W-1:0] : shifted[W-1:0];
        acc <= {acc[W-2:0], step_ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign busy = run;
  assign quot = acc;

  // R4: the quotient is a floor: q*d <= n and the remainder is below d
  assert_quot_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && dvs_q != '0) |->
      (({{W{1'b0}}, quot} * {{W{1'b0}}, dvs_q}) <= {{W{1'b0}}, dvd_q}) && (rem < dvs_q));
endmodule

// File: rtl/rate_fit_best.sv
module rate_fit_best #(
  parameter int FREQ_W = 32,
  parameter int DIVQ_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              offer,
  input  logic [FREQ_W-1:0] target,
  input  logic [1:0]        cand_src,
  input  logic [1:0]        cand_pidx,
  input  logic [DIVQ_W-1:0] cand_div,
  input  logic [FREQ_W-1:0] cand_rate,
  output logic              found,
  output logic [1:0]        best_src,
  output logic [1:0]        best_pidx,
  output logic [DIVQ_W-1:0] best_div,
  output logic [FREQ_W-1:0] best_rate
);
  function automatic logic [FREQ_W-1:0] abs_diff(input logic [FREQ_W-1:0] a,
                                                 input logic [FREQ_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  logic [FREQ_W-1:0] best_err;
  logic [FREQ_W-1:0] cand_err;
  logic              best_take;   // a candidate replaces the kept one

  assign cand_err  = abs_diff(cand_rate, target);
  assign best_take = offer && (!found || (cand_err < best_err));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      found     <= 1'b0;
      best_src  <= '0;
      best_pidx <= '0;
      best_div  <= '0;
      best_rate <= '0;
      best_err  <= '0;
    end else if (best_take) begin
      found     <= 1'b1;
      best_src  <= cand_src;
      best_pidx <= cand_pidx;
      best_div  <= cand_div;
      best_rate <= cand_rate;
      best_err  <= cand_err;
    end
  end

  // R6: an equal or worse error never displaces the kept candidate
  assert_tie_keeps_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (offer && !clear && found && cand_err >= best_err) |=>
      ($stable(best_div) && $stable(best_src) && $stable(best_pidx) && $stable(best_rate)));

  // R6: the first valid candidate is always taken
  assert_first_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (offer && !clear && !found) |=> (found && best_rate == $past(cand_rate)));
endmodule

// File: rtl/rate_fit_search.sv
module rate_fit_search
  import rate_fit_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int CALC_W = 40,
  parameter int DIVQ_W = 7,
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] req_rate,
  input  logic [FREQ_W-1:0] ref_rate,
  input  logic [FREQ_W-1:0] pll_a_rate,
  input  logic [FREQ_W-1:0] pll_b_rate,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              sel_pll,
  output logic              sel_pll_b,
  output logic [1:0]        pre_code,
  output logic [DIVQ_W-1:0] div_val,
  output logic [FREQ_W-1:0] achieved
);
  localparam int LAST_SRC = NSRC - 1;
  localparam int LAST_PRE = NPRE - 1;

  function automatic logic [FREQ_W-1:0] limit_req(input logic [FREQ_W-1:0] req,
                                                  input logic [FREQ_W-1:0] a,
                                                  input logic [FREQ_W-1:0] b,
                                                  input logic [FREQ_W-1:0] c);
    logic [FREQ_W-1:0] top;
    top = a >> 2;
    if ((b >> 2) > top) top = b >> 2;
    if ((c >> 2) > top) top = c >> 2;
    return (req < top) ? req : top;
  endfunction

  function automatic logic [2:0] pre_factor(input logic [1:0] pidx);
    return 3'(PRE_BASE) + {1'b0, pidx};
  endfunction

  fit_state_e        state;
  logic [FREQ_W-1:0] rate_q;
  logic [FREQ_W-1:0] src_q [NSRC];
  logic [FREQ_W-1:0] src_in [NSRC];
  logic [1:0]        s_idx, p_idx;
  logic [DIVQ_W-1:0] div_q;

  logic              start_acc;      // accepted start
  logic              last_cand;      // final source/factor pair
  logic              cand_in_range;  // divider within limits
  logic              cand_offer;     // achieved rate ready for judging
  logic [2:0]        factor;
  logic [FREQ_W-1:0] cur_src;

  logic              div_go, div_busy, div_fin;
  logic [CALC_W-1:0] div_dvd, div_dvs, div_quot;

  assign start_acc = (state == ST_IDLE) && start;
  assign src_in[0] = ref_rate;
  assign src_in[1] = pll_a_rate;
  assign src_in[2] = pll_b_rate;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)         src_q[g] <= '0;
      else if (start_acc) src_q[g] <= src_in[g];
    end
  end

  assign factor        = pre_factor(p_idx);
  assign cur_src       = src_q[s_idx];
  assign last_cand     = (s_idx == 2'(LAST_SRC)) && (p_idx == 2'(LAST_PRE));
  assign cand_in_range = (div_quot >= CALC_W'(DIV_LO)) && (div_quot <= CALC_W'(DIV_HI));
  assign cand_offer    = (state == ST_AWAIT) && div_fin;

  // both divisions share the doubled source as dividend
  assign div_go  = (state == ST_QGO) || (state == ST_AGO);
  assign div_dvd = CALC_W'({cur_src, 1'b0});
  assign div_dvs = (state == ST_QGO) ? (CALC_W'(rate_q) * CALC_W'(factor))
                                     : (CALC_W'(factor) * CALC_W'(div_q));

  rate_fit_udiv #(.W(CALC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .dvd   (div_dvd),
    .dvs   (div_dvs),
    .busy  (div_busy),
    .fin   (div_fin),
    .quot  (div_quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rate_q <= '0;
      s_idx  <= '0;
      p_idx  <= '0;
      div_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          rate_q <= limit_req(req_rate, ref_rate, pll_a_rate, pll_b_rate);
          s_idx  <= '0;
          p_idx  <= '0;
          state  <= ST_QGO;
        end
        ST_QGO:   state <= ST_QWAIT;
        ST_QWAIT: if (div_fin) begin
          if (cand_in_range) begin
            div_q <= div_quot[DIVQ_W-1:0];
            state <= ST_AGO;
          end else begin
            state <= ST_NEXT;
          end
        end
        ST_AGO:   state <= ST_AWAIT;
        ST_AWAIT: if (div_fin) state <= ST_NEXT;
        ST_NEXT: begin
          if (last_cand) begin
            state <= ST_DONE;
          end else begin
            if (p_idx == 2'(LAST_PRE)) begin
              p_idx <= '0;
              s_idx <= s_idx + 1'b1;
            end else begin
              p_idx <= p_idx + 1'b1;
            end
            state <= ST_QGO;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  logic [1:0] best_src, best_pidx;

  rate_fit_best #(.FREQ_W(FREQ_W), .DIVQ_W(DIVQ_W)) u_best (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_acc),
    .offer     (cand_offer),
    .target    (rate_q),
    .cand_src  (s_idx),
    .cand_pidx (p_idx),
    .cand_div  (div_q),
    .cand_rate (div_quot[FREQ_W-1:0]),
    .found     (found),
    .best_src  (best_src),
    .best_pidx (best_pidx),
    .best_div  (div_val),
    .best_rate (achieved)
  );

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign sel_pll   = found && (best_src != 2'd0);
  assign sel_pll_b = found && (best_src == 2'd2);
  assign pre_code  = found ? (best_pidx + 2'd1) : 2'd0;

  // R9: the end pulse lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: a running search is not cut short by anything at the ports
  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R4: a reported winner has a divider inside the allowed span
  assert_found_div_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (div_val >= DIVQ_W'(DIV_LO) && div_val <= DIVQ_W'(DIV_HI)));

  // R8: an empty search reports zeros
  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (achieved == '0 && div_val == '0 && pre_code == 2'd0));

  // R7: a winner always carries a nonzero predivider code
  assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (pre_code != 2'd0));

  // R2: the division never runs while the engine is idle
  assert_div_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !div_busy);
endmodule

// File: tb/rate_fit_search_bench.sv
module rate_fit_search_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_rate = '0, ref_rate = '0, pll_a_rate = '0, pll_b_rate = '0;
  logic        busy, done, found, sel_pll, sel_pll_b;
  logic [1:0]  pre_code;
  logic [6:0]  div_val;
  logic [31:0] achieved;

  always #2.5 clk = ~clk;   // 200 MHz

  rate_fit_search u_rate_fit_search (
    .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
    .ref_rate(ref_rate), .pll_a_rate(pll_a_rate), .pll_b_rate(pll_b_rate),
    .busy(busy), .done(done), .found(found), .sel_pll(sel_pll),
    .sel_pll_b(sel_pll_b), .pre_code(pre_code), .div_val(div_val),
    .achieved(achieved)
  );

  typedef struct {
    bit          fnd;
    logic [31:0] ach;
    logic [6:0]  dv;
    logic [1:0]  pc;
    bit          sa;
    bit          sb;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   n_done  = 0;
  int   n_push  = 0;

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent model of the requirements, written as plain nested search
  function automatic exp_t model(input longint unsigned req, input longint unsigned r0,
                                 input longint unsigned r1, input longint unsigned r2);
    exp_t e;
    longint unsigned src[3];
    longint unsigned lim, tgt, best_e;
    e = '{fnd: 0, ach: 0, dv: 0, pc: 0, sa: 0, sb: 0};
    src[0] = r0; src[1] = r1; src[2] = r2;
    lim = r0 / 4;
    if (r1 / 4 > lim) lim = r1 / 4;
    if (r2 / 4 > lim) lim = r2 / 4;
    tgt = (req < lim) ? req : lim;
    best_e = 0;
    if (tgt == 0) return e;
    for (int s = 0; s < 3; s++) begin
      for (int f = 4; f <= 6; f++) begin
        longint unsigned m, q, a, er;
        m = 2 * src[s];
        q = m / (tgt * f);
        if (q < 2 || q > 127) continue;
        a = m / (f * q);
        er = (a > tgt) ? a - tgt : tgt - a;
        if (!e.fnd || er < best_e) begin
          e.fnd = 1; e.ach = a[31:0]; e.dv = q[6:0]; e.pc = 2'(f - 3);
          e.sa = (s != 0); e.sb = (s == 2); best_e = er;
        end
      end
    end
    return e;
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_job(input logic [31:0] rq, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c,
                         input bit poke_mid);
    wait_idle();
    req_rate = rq; ref_rate = a; pll_a_rate = b; pll_b_rate = c;
    exp_q.push_back(model(rq, a, b, c));
    n_push++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    if (poke_mid) begin
      repeat (30) @(negedge clk);
      req_rate = 32'd1; ref_rate = 32'd999; pll_a_rate = 32'd0; pll_b_rate = 32'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R1 start while busy ignored", busy, 1);
    end
    while (!done) @(negedge clk);
    begin
      logic [31:0] held;
      held = achieved;
      @(negedge clk);
      check(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
      repeat (3) @(negedge clk);
      check(achieved == held, "R9 result held", achieved, held);
    end
  endtask

  // monitor: compare each finished search with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (exp_q.size() == 0) begin
        check(0, "R1 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(found == e.fnd, "R8 found", found, e.fnd);
        check(achieved == e.ach, "R5 achieved", achieved, e.ach);
        check(div_val == e.dv, "R4 div_val", div_val, e.dv);
        check(pre_code == e.pc, "R7 pre_code", pre_code, e.pc);
        check(sel_pll == e.sa, "R7 sel_pll", sel_pll, e.sa);
        check(sel_pll_b == e.sb, "R7 sel_pll_b", sel_pll_b, e.sb);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !found && achieved == 0, "reset state", {busy, done, found}, 0);

    // R3/R5: typical request against three distinct sources
    run_job(32'd25_000_000, 32'd14_745_600, 32'd400_000_000, 32'd384_000_000, 0);
    run_job(32'd6_500_000, 32'd14_745_600, 32'd332_000_000, 32'd192_000_000, 0);
    // R2: request far above the limit
    run_job(32'hFFFF_FFFF, 32'd14_745_600, 32'd0, 32'd0, 0);
    // R4/R8: zero request finds nothing
    run_job(32'd0, 32'd14_745_600, 32'd400_000_000, 32'd0, 0);
    check(found == 1'b0 && achieved == 0, "R8 zero request empty", achieved, 0);
    // R8: tiny request overflows every divider
    run_job(32'd1, 32'd14_745_600, 32'd0, 32'd0, 0);
    check(found == 1'b0 && div_val == 0, "R4 all dividers over range", div_val, 0);
    // R6: equal sources, exact hit at factor 4: the reference must win
    run_job(32'd10_000_000, 32'd100_000_000, 32'd100_000_000, 32'd100_000_000, 0);
    check(sel_pll == 1'b0 && pre_code == 2'd1 && div_val == 7'd5,
          "R6 tie keeps earliest", {sel_pll, pre_code, div_val}, {1'b0, 2'd1, 7'd5});
    // R7: only the second PLL is running
    run_job(32'd20_000_000, 32'd0, 32'd0, 32'd300_000_000, 0);
    check(sel_pll_b == 1'b1 && sel_pll == 1'b1 && pre_code == 2'd2 && div_val == 7'd6,
          "R7 second PLL wins", {sel_pll_b, pre_code, div_val}, {1'b1, 2'd2, 7'd6});
    // R1: start pulsed mid-search is ignored
    run_job(32'd33_000_000, 32'd14_745_600, 32'd266_000_000, 32'd240_000_000, 1);

    wait_idle();
    repeat (5) @(negedge clk);
    check(n_done == n_push, "R1 one done per accepted start", n_done, n_push);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule